// File: doc/BRIEF.md
# Interleaved Downstream Payload Extractor with Frame-Aligned Sleep

This block sits directly behind clock and data recovery in a terminal of a bit-interleaved passive optical network. The line carries one bit per clock. Each frame holds a payload section of `PAY_LEN` bits. This terminal owns the payload bits picked out by a per-frame allocation, which is a start offset and a stride. The block forwards only those bits, one per `pay_valid` strobe, so all logic behind it runs at the user rate instead of the line rate.

The block also carries out a sleep command whose length is a whole number of frames. While the terminal sleeps, the block ignores the payload-start marker and emits nothing. A frame timer `FRAME_LEN` bits long keeps running through the sleep. When the last sleeping frame ends, the timer supplies the frame boundary itself. The block then resumes on that boundary, aligned with the line, and needs no new marker. Decoding the allocation and the sleep command happens upstream of this block.

Top module: `ilv_payload_extract`

## Requirements
- R1: After reset, `pay_valid`, `pay_bit` and `asleep` are low and the block holds no allocation (stride 0), so a frame arriving before any load produces no output.
- R2: The payload position p counts from 0 in the cycle that carries the frame boundary. With active allocation (S, K), the line bit at position p is emitted when all of these hold: p < `PAY_LEN`, K ≠ 0, p ≥ S and (p − S) mod K = 0. The bit appears on `pay_bit` with `pay_valid` high one clock after its line cycle.
- R3: An `alloc_load` stores a pending allocation, and each awake frame boundary copies the pending value into the active one. A load in the same cycle as a boundary applies only from the following frame. An allocation stays in force until it is replaced.
- R4: A stride of 0 produces no output for the frame. An offset at or above `PAY_LEN` also produces no output.
- R5: `pay_bit` is low whenever `pay_valid` is low.
- R6: No bit is emitted from payload position `PAY_LEN` onward until the next frame boundary.
- R7: A `sleep_req` with a nonzero `sleep_frames` N, raised during a frame, lets that frame finish normally. Sleep starts at the next boundary: that frame's payload is suppressed and `asleep` goes high one clock later. A request with N = 0 is ignored.
- R8: While asleep, `pay_start` is ignored. Frame boundaries come from a timer that restarts at each accepted boundary and marks a new one every `FRAME_LEN` cycles. At the Nth such boundary the block wakes, `asleep` falls one clock later, and the payload starting at that boundary is processed with the pending allocation.
- R9: `asleep` stays high for exactly N·`FRAME_LEN` cycles, and `pay_valid` stays low throughout.
- R10: A sleep request raised while asleep, or in the cycle that starts a sleep, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_bit | input | 1 | Recovered line bit for this cycle |
| pay_start | input | 1 | High in the cycle of payload bit 0 of a frame (frame boundary) |
| alloc_load | input | 1 | Stores `alloc_offset`/`alloc_stride` as the pending allocation |
| alloc_offset | input | AW | Start offset S within the payload section |
| alloc_stride | input | AW | Sampling stride K; 0 means no allocation |
| sleep_req | input | 1 | Requests sleep for `sleep_frames` frames |
| sleep_frames | input | SW | Sleep length in whole frames |
| pay_bit | output | 1 | Extracted payload bit |
| pay_valid | output | 1 | Strobe marking a valid `pay_bit` |
| asleep | output | 1 | High for the whole sleep period |

## Verification
The situation hardest to reach from the ports is a wake-up that relies only on the internal frame timer. In that case, markers presented during sleep must have no effect, and the first payload after wake must line up with a boundary the block generated itself. The stimulus drives `pay_start` on a fixed frame grid and adds stray markers in the middle of sleeping frames. It raises sleep requests in the middle of frames, including zero-length requests and requests made during a sleep. The bench checks every cycle against a model computed from the requirements, through directed frames and through seeded random frames that mix reallocations and sleeps.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  typedef enum logic {
    IPX_RUN  = 1'b0,
    IPX_DOZE = 1'b1
  } ipx_mode_e;
endpackage

// File: rtl/ipx_frame_timer.sv
module ipx_frame_timer #(
  parameter int FRAME_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pay_start_i,
  input  logic asleep_i,
  output logic bnd_o
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] fpos_q, fpos_d;
  logic             awake_bnd, doze_bnd;

  always_comb begin
    awake_bnd = pay_start_i & ~asleep_i;
    doze_bnd  = asleep_i & (fpos_q == '0);
    bnd_o     = awake_bnd | doze_bnd;
    if (awake_bnd)
      fpos_d = POS_W'(1);
    else if (fpos_q == LAST)
      fpos_d = '0;
    else
      fpos_d = fpos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fpos_q <= '0;
    else        fpos_q <= fpos_d;
  end

  // R8: while asleep, a stray marker must not move the timer
  a_r8_marker_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_i && $past(asleep_i) && pay_start_i && fpos_q != '0) |-> !bnd_o);
endmodule

// File: rtl/ipx_sleep_ctrl.sv
module ipx_sleep_ctrl
  import ipx_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_i,
  input  logic          req_i,
  input  logic [SW-1:0] frames_i,
  output logic          asleep_o,
  output logic          start_o
);
  ipx_mode_e     mode_q, mode_d;
  logic [SW-1:0] rem_q, rem_d;
  logic          pend_v_q, pend_v_d;
  logic [SW-1:0] pend_n_q, pend_n_d;
  logic          take;

  always_comb begin
    mode_d   = mode_q;
    rem_d    = rem_q;
    pend_v_d = pend_v_q;
    pend_n_d = pend_n_q;
    start_o  = 1'b0;
    take     = 1'b0;
    if (bnd_i) begin
      case (mode_q)
        IPX_RUN: begin
          if (pend_v_q) begin
            mode_d   = IPX_DOZE;
            rem_d    = pend_n_q;
            pend_v_d = 1'b0;
            take     = 1'b1;
          end else begin
            start_o = 1'b1;
          end
        end
        default: begin
          if (rem_q == SW'(1)) begin
            mode_d  = IPX_RUN;
            start_o = 1'b1;
          end else begin
            rem_d = rem_q - 1'b1;
          end
        end
      endcase
    end
    if (req_i && (frames_i != '0) && (mode_q == IPX_RUN) && !take) begin
      pend_v_d = 1'b1;
      pend_n_d = frames_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= IPX_RUN;
      rem_q    <= '0;
      pend_v_q <= 1'b0;
      pend_n_q <= '0;
    end else begin
      mode_q   <= mode_d;
      rem_q    <= rem_d;
      pend_v_q <= pend_v_d;
      pend_n_q <= pend_n_d;
    end
  end

  assign asleep_o = (mode_q == IPX_DOZE);

  // R7: sleep begins only on a frame boundary
  a_r7_enter_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(bnd_i));
  // R8: wake-up happens only on a frame boundary
  a_r8_wake_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> $past(bnd_i));
endmodule

// File: rtl/ipx_picker.sv
module ipx_picker #(
  parameter int PAY_LEN = 48,
  parameter int AW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_i,
  input  logic          start_i,
  input  logic          line_bit_i,
  input  logic          load_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [AW-1:0] stride_i,
  output logic          bit_o,
  output logic          vld_o
);
  localparam int LW = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1;
  localparam logic [LW-1:0] LEFT_INIT = LW'(PAY_LEN - 1);

  logic [AW-1:0] pofs_q, pstr_q;
  logic [AW-1:0] phase_q, phase_d, stride_q, stride_d;
  logic [LW-1:0] left_q, left_d;
  logic          act_q, act_d;
  logic          vld_q, bit_q;
  logic          in_win, hit;
  logic [AW-1:0] ph, k;
  logic [LW-1:0] rem;

  always_comb begin
    in_win = start_i | (act_q & ~bnd_i);
    ph     = start_i ? pofs_q : phase_q;
    k      = start_i ? pstr_q : stride_q;
    rem    = start_i ? LEFT_INIT : left_q;
    hit    = in_win && (k != '0) && (ph == '0);

    stride_d = start_i ? pstr_q : stride_q;
    act_d    = in_win && (rem != '0) && (k != '0);
    left_d   = (rem != '0) ? rem - 1'b1 : '0;
    if (hit)
      phase_d = k - 1'b1;
    else if (ph != '0)
      phase_d = ph - 1'b1;
    else
      phase_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pofs_q <= '0;
      pstr_q <= '0;
    end else if (load_i) begin
      pofs_q <= ofs_i;
      pstr_q <= stride_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      stride_q <= '0;
      left_q   <= '0;
      act_q    <= 1'b0;
      vld_q    <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      stride_q <= stride_d;
      left_q   <= left_d;
      act_q    <= act_d;
      vld_q    <= hit;
      bit_q    <= hit & line_bit_i;
    end
  end

  assign vld_o = vld_q;
  assign bit_o = bit_q;

  // R6: a strobe only comes from a cycle inside an open payload window
  a_r6_valid_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(start_i || act_q));
  // R2: back-to-back strobes inside one window imply a stride of one
  a_r2_adjacent_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(vld_q) && !$past(start_i)) |-> (stride_q == AW'(1)));
endmodule

// File: rtl/ilv_payload_extract.sv
module ilv_payload_extract #(
  parameter int FRAME_LEN = 64,
  parameter int PAY_LEN   = 48,
  parameter int AW        = 7,
  parameter int SW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_bit,
  input  logic          pay_start,
  input  logic          alloc_load,
  input  logic [AW-1:0] alloc_offset,
  input  logic [AW-1:0] alloc_stride,
  input  logic          sleep_req,
  input  logic [SW-1:0] sleep_frames,
  output logic          pay_bit,
  output logic          pay_valid,
  output logic          asleep
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       bnd, start, doze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ipx_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pay_start_i(pay_start),
    .asleep_i   (doze),
    .bnd_o      (bnd)
  );

  ipx_sleep_ctrl #(.SW(SW)) u_sleep (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bnd_i   (bnd),
    .req_i   (sleep_req),
    .frames_i(sleep_frames),
    .asleep_o(doze),
    .start_o (start)
  );

  ipx_picker #(.PAY_LEN(PAY_LEN), .AW(AW)) u_pick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bnd_i     (bnd),
    .start_i   (start),
    .line_bit_i(line_bit),
    .load_i    (alloc_load),
    .ofs_i     (alloc_offset),
    .stride_i  (alloc_stride),
    .bit_o     (pay_bit),
    .vld_o     (pay_valid)
  );

  assign asleep = doze;

  // R9: nothing is emitted while asleep
  a_r9_quiet_while_asleep: assert property (@(posedge clk) disable iff (!rst_int_n)
    asleep |-> !pay_valid);
endmodule

// File: tb/tb_ilv_payload_extract.sv
module tb_ilv_payload_extract;
  localparam int FL = 64;
  localparam int PL = 48;
  localparam int AW = 7;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_bit = 1'b0, pay_start = 1'b0, alloc_load = 1'b0, sleep_req = 1'b0;
  logic [AW-1:0] alloc_offset = '0, alloc_stride = '0;
  logic [SW-1:0] sleep_frames = '0;
  logic pay_bit, pay_valid, asleep;

  always #10 clk = ~clk;

  ilv_payload_extract #(.FRAME_LEN(FL), .PAY_LEN(PL), .AW(AW), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .pay_start(pay_start),
    .alloc_load(alloc_load), .alloc_offset(alloc_offset), .alloc_stride(alloc_stride),
    .sleep_req(sleep_req), .sleep_frames(sleep_frames),
    .pay_bit(pay_bit), .pay_valid(pay_valid), .asleep(asleep));

  int checks = 0, errors = 0;
  string tag = "R1";
  int vcnt = 0, scnt = 0;
  bit e_v = 0, e_b = 0, e_s = 0;
  bit m_sleep = 0, m_pend = 0, m_inpay = 0;
  int m_left = 0, m_pendn = 0, m_pS = 0, m_pK = 0, m_S = 0, m_K = 0, m_p = 0, m_cnt = 0;

  function automatic bit chosen(int p, int s, int k);
    return (p < PL) && (k != 0) && (p >= s) && (((p - s) % k) == 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit ps, bit ld, int s, int k, bit sr, int sn);
    bit lb, bnd, was, entered;
    @(negedge clk);
    chk(tag, pay_valid, e_v);
    chk(e_v ? tag : "R5", pay_bit, e_b);
    chk(tag, asleep, e_s);
    vcnt += pay_valid;
    scnt += asleep;
    lb = 1'($urandom);
    line_bit = lb; pay_start = ps; alloc_load = ld;
    alloc_offset = AW'(s); alloc_stride = AW'(k);
    sleep_req = sr; sleep_frames = SW'(sn);
    bnd = m_sleep ? (m_cnt == FL) : ps;
    was = m_sleep; entered = 0;
    if (bnd) begin
      if (m_sleep) begin
        m_left--;
        if (m_left == 0) m_sleep = 0;
      end else if (m_pend) begin
        m_sleep = 1; m_left = m_pendn; m_pend = 0; entered = 1;
      end
      if (!m_sleep) begin
        m_S = m_pS; m_K = m_pK; m_p = 0; m_inpay = 1;
      end else m_inpay = 0;
    end
    e_v = m_inpay && chosen(m_p, m_S, m_K);
    e_b = e_v & lb;
    m_p++;
    m_cnt = bnd ? 1 : m_cnt + 1;
    if (sr && sn != 0 && !was && !entered) begin m_pend = 1; m_pendn = sn; end
    if (ld) begin m_pS = s; m_pK = k; end
    e_s = m_sleep;
  endtask

  // one frame on the fixed grid; negative positions disable an event
  task automatic frame(int ld_at, int s, int k, int sr_at, int sn, int bogus_at);
    for (int i = 0; i < FL; i++)
      step(i == 0 || i == bogus_at, i == ld_at, s, k, i == sr_at, sn);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      chk("R1", pay_valid, 0); chk("R1", pay_bit, 0); chk("R1", asleep, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);
    // R1: no allocation yet
    tag = "R1"; vcnt = 0;
    frame(-1, 0, 0, -1, 0, -1);
    chk("R1", vcnt, 0);
    // R2: offset 3 stride 5, loaded mid-frame, then every bit
    tag = "R2";
    frame(10, 3, 5, -1, 0, -1);
    frame(20, 0, 1, -1, 0, -1);
    frame(-1, 0, 0, -1, 0, -1);
    // R3: load in the boundary cycle applies to the following frame
    tag = "R3";
    frame(0, 2, 9, -1, 0, -1);
    frame(-1, 0, 0, -1, 0, -1);
    // R4: zero stride and offset beyond the payload
    tag = "R4";
    frame(5, 0, 0, -1, 0, -1);
    vcnt = 0; frame(5, PL, 1, -1, 0, -1);
    chk("R4", vcnt, 0);
    vcnt = 0; frame(5, PL - 1, 3, -1, 0, -1);
    chk("R4", vcnt, 0);
    vcnt = 0; frame(5, 0, 7, -1, 0, -1);
    chk("R4", vcnt, 1);
    // R6: stride 7 from 0 ends at position 42
    tag = "R6";
    vcnt = 0; frame(-1, 0, 0, -1, 0, -1);
    chk("R6", vcnt, 7);
    // R7: zero-length request ignored, then a two-frame sleep
    tag = "R7";
    frame(-1, 0, 0, 15, 0, -1);
    frame(-1, 0, 0, 20, 2, -1);
    tag = "R8"; scnt = 0; vcnt = 0;
    frame(-1, 0, 0, -1, 0, 30);
    frame(-1, 0, 0, -1, 0, 17);
    tag = "R9";
    frame(-1, 0, 0, -1, 0, -1);
    chk("R9", scnt, 2 * FL);
    // R10: request during a sleep is ignored
    tag = "R10";
    frame(-1, 0, 0, 40, 1, -1);
    scnt = 0;
    frame(-1, 0, 0, 5, 3, 9);
    frame(-1, 0, 0, -1, 0, -1);
    frame(-1, 0, 0, -1, 0, -1);
    chk("R10", scnt, FL);
    // R2: seeded random frames mixing reallocation and sleep
    tag = "R2";
    for (int f = 0; f < 40; f++) begin
      int ld_at, sr_at, bg;
      ld_at = ($urandom % 3 == 0) ? -1 : int'($urandom % FL);
      sr_at = ($urandom % 6 == 0) ? int'($urandom % FL) : -1;
      bg    = ($urandom % 4 == 0) ? int'(1 + $urandom % (FL - 1)) : -1;
      frame(ld_at, int'($urandom % 52), int'($urandom % 9), sr_at,
            int'($urandom % 4), bg);
    end
    step(0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule